// File: doc/BRIEF.md
# Receive Path Test-Mode Source Selector

This block decides what the receive path hands downstream as I/Q sample pairs. In normal operation it forwards the converter-derived receive samples. For link self-test it can instead forward the transmit samples, looped back digitally, or a deterministic counting pattern. The counting pattern comes in two forms. A narrow form puts the count on I and its bitwise complement on Q. A wide form uses a counter twice the sample width and splits it, with the low half on I and the high half on Q.

A three-bit mode word selects the source. Two control inputs gate the block: a receive enable and a receive reset. A sample strobe paces the output. Each strobe accepted while receive is enabled produces exactly one registered I/Q pair and a one-cycle valid pulse. The counter advances once per accepted strobe. A receive reset clears the counter and the output registers. Filtering, decimation and register access are outside the block.

Top module: `rx_test_source`

## Requirements
- R1: After the synchronous reset `rst`, `out_valid` is 0, `out_i` and `out_q` are 0, and the internal counter starts from 0.
- R2: With mode 3'b000, an accepted strobe presents `adc_i`/`adc_q` on `out_i`/`out_q` one clock later.
- R3: With mode 3'b001 (bit 0 = loopback), an accepted strobe presents `tx_i`/`tx_q` one clock later.
- R4: With mode bit 1 set and bit 2 clear, an accepted strobe presents I = low SAMPLE_W bits of the count and Q = the bitwise complement of that value.
- R5: With mode bit 2 set, an accepted strobe presents I = low SAMPLE_W bits of the 2*SAMPLE_W-bit count and Q = its high SAMPLE_W bits, whatever bits 0 and 1 are. The count carries from the low half into the high half.
- R6: When a counting bit (bit 1 or bit 2) is set together with loopback bit 0, the counting pattern is presented and the transmit samples are not.
- R7: A strobe is accepted when `strobe` is 1, `rx_enable` is 1 and `rx_reset` is 0. The count shown is the value before the step, and the counter then advances by exactly one. Strobes that are not accepted leave the counter unchanged.
- R8: `rx_reset` at 1 clears the counter to 0 and `out_i`/`out_q` to 0 one clock later, and keeps `out_valid` at 0, even if `strobe` and `rx_enable` are both 1.
- R9: `out_valid` is 1 for exactly the one cycle after each accepted strobe, and 0 after any cycle without an accepted strobe.
- R10: In cycles with neither an accepted strobe nor `rx_reset`, `out_i` and `out_q` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive enable; strobes are accepted only when 1 |
| rx_reset | input | 1 | Receive-path reset; clears counter and outputs |
| mode | input | 3 | Source select: bit 0 loopback, bit 1 counting, bit 2 wide counter |
| strobe | input | 1 | Sample strobe |
| adc_i | input | SAMPLE_W | Normal receive sample, I |
| adc_q | input | SAMPLE_W | Normal receive sample, Q |
| tx_i | input | SAMPLE_W | Transmit sample for loopback, I |
| tx_q | input | SAMPLE_W | Transmit sample for loopback, Q |
| out_i | output | SAMPLE_W | Selected I sample |
| out_q | output | SAMPLE_W | Selected Q sample |
| out_valid | output | 1 | One-cycle pulse per accepted strobe |

## Verification
The assertions assume that the mode word, the sample inputs and the control inputs are stable across the clock edge at which they are sampled. The loopback and pass-through checks compare an output with the inputs seen one edge earlier. The bench changes every input only on the falling clock edge and keeps the mode fixed within each sweep. It covers all eight mode encodings, with strobes both back to back and with gaps. A long back-to-back run in wide-counter mode drives the count across the carry from the low half into the high half, so the bench never relies on inputs changing in mid-cycle.

// File: rtl/rxts_pkg.sv
package rxts_pkg;

    localparam int unsigned MODE_W        = 3;
    localparam int unsigned MODE_LOOP_BIT = 0;
    localparam int unsigned MODE_CNT_BIT  = 1;
    localparam int unsigned MODE_WIDE_BIT = 2;

    typedef enum logic [1:0] {
        SRC_ADC   = 2'd0,
        SRC_LOOP  = 2'd1,
        SRC_CNT16 = 2'd2,
        SRC_CNT32 = 2'd3
    } src_e;

    // Counting outranks loopback; the wide counter outranks the narrow one.
    function automatic src_e pick_source(input logic [MODE_W-1:0] m);
        if (m[MODE_WIDE_BIT])      return SRC_CNT32;
        else if (m[MODE_CNT_BIT])  return SRC_CNT16;
        else if (m[MODE_LOOP_BIT]) return SRC_LOOP;
        else                       return SRC_ADC;
    endfunction

endpackage

// File: rtl/rxts_ctrl.sv
module rxts_ctrl
    import rxts_pkg::*;
(
    input  logic              strobe,
    input  logic              rx_enable,
    input  logic              rx_reset,
    input  logic [MODE_W-1:0] mode,
    output logic              accept,
    output logic              clear,
    output src_e              src
);
    always_comb begin
        clear  = rx_reset;
        accept = strobe && rx_enable && !rx_reset;
        src    = pick_source(mode);
    end
endmodule

// File: rtl/rxts_counter.sv
module rxts_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            count <= '0;
        else if (step)
            count <= count + {{(CNT_W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/rxts_mux.sv
module rxts_mux
    import rxts_pkg::*;
#(
    parameter int unsigned W = 16,
    localparam int unsigned CW = 2 * W
) (
    input  src_e          src,
    input  logic [W-1:0]  adc_i,
    input  logic [W-1:0]  adc_q,
    input  logic [W-1:0]  tx_i,
    input  logic [W-1:0]  tx_q,
    input  logic [CW-1:0] count,
    output logic [W-1:0]  nxt_i,
    output logic [W-1:0]  nxt_q
);
    logic [W-1:0] cnt_lo;
    logic [W-1:0] cnt_hi;
    logic [W-1:0] cnt_inv;

    assign cnt_lo = count[W-1:0];
    assign cnt_hi = count[CW-1:W];

    for (genvar b = 0; b < W; b++) begin : g_inv
        assign cnt_inv[b] = ~cnt_lo[b];
    end

    always_comb begin
        unique case (src)
            SRC_LOOP:  begin nxt_i = tx_i;   nxt_q = tx_q;    end
            SRC_CNT16: begin nxt_i = cnt_lo; nxt_q = cnt_inv; end
            SRC_CNT32: begin nxt_i = cnt_lo; nxt_q = cnt_hi;  end
            default:   begin nxt_i = adc_i;  nxt_q = adc_q;   end
        endcase
    end
endmodule

// File: rtl/rxts_out_reg.sv
module rxts_out_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] nxt_i,
    input  logic [W-1:0] nxt_q,
    output logic [W-1:0] out_i,
    output logic [W-1:0] out_q,
    output logic         out_valid
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            out_i     <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= load;
            if (load) begin
                out_i <= nxt_i;
                out_q <= nxt_q;
            end
        end
    end
endmodule

// File: rtl/rx_test_source.sv
module rx_test_source
    import rxts_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16,
    localparam int unsigned CNT_W = 2 * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_enable,
    input  logic                rx_reset,
    input  logic [MODE_W-1:0]   mode,
    input  logic                strobe,
    input  logic [SAMPLE_W-1:0] adc_i,
    input  logic [SAMPLE_W-1:0] adc_q,
    input  logic [SAMPLE_W-1:0] tx_i,
    input  logic [SAMPLE_W-1:0] tx_q,
    output logic [SAMPLE_W-1:0] out_i,
    output logic [SAMPLE_W-1:0] out_q,
    output logic                out_valid
);
    logic                accept;
    logic                clear;
    src_e                src;
    logic [CNT_W-1:0]    count_q;
    logic [SAMPLE_W-1:0] nxt_i;
    logic [SAMPLE_W-1:0] nxt_q;

    rxts_ctrl ctrl_i (
        .strobe    (strobe),
        .rx_enable (rx_enable),
        .rx_reset  (rx_reset),
        .mode      (mode),
        .accept    (accept),
        .clear     (clear),
        .src       (src)
    );

    rxts_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .step  (accept),
        .count (count_q)
    );

    rxts_mux #(.W(SAMPLE_W)) mux_i (
        .src   (src),
        .adc_i (adc_i),
        .adc_q (adc_q),
        .tx_i  (tx_i),
        .tx_q  (tx_q),
        .count (count_q),
        .nxt_i (nxt_i),
        .nxt_q (nxt_q)
    );

    rxts_out_reg #(.W(SAMPLE_W)) oreg_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .load      (accept),
        .nxt_i     (nxt_i),
        .nxt_q     (nxt_q),
        .out_i     (out_i),
        .out_q     (out_q),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/rxts_checker.sv
module rxts_checker #(
    parameter int unsigned W = 16,
    localparam int unsigned CW = 2 * W
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_enable,
    input logic          rx_reset,
    input logic [2:0]    mode,
    input logic          strobe,
    input logic [W-1:0]  adc_i,
    input logic [W-1:0]  adc_q,
    input logic [W-1:0]  tx_i,
    input logic [W-1:0]  tx_q,
    input logic [W-1:0]  out_i,
    input logic [W-1:0]  out_q,
    input logic          out_valid,
    input logic [CW-1:0] cnt
);
    logic acc;
    assign acc = strobe && rx_enable && !rx_reset;

    p_valid_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);

    p_no_valid_without_accept_r9: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !out_valid);

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!acc && !rx_reset) |=> ($stable(out_i) && $stable(out_q)));

    p_rx_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
        rx_reset |=> (out_i == '0 && out_q == '0 && !out_valid && cnt == '0));

    p_adc_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && mode == 3'b000) |=> (out_i == $past(adc_i) && out_q == $past(adc_q)));

    p_loopback_r3: assert property (@(posedge clk) disable iff (rst)
        (acc && mode == 3'b001) |=> (out_i == $past(tx_i) && out_q == $past(tx_q)));

    p_narrow_complement_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && mode[2:1] == 2'b01) |=> (out_q == ~out_i));

    p_wide_split_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && mode[2]) |=> ({out_q, out_i} == $past(cnt)));

    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        acc |=> (cnt == $past(cnt) + 1'b1));

    p_count_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!acc && !rx_reset) |=> $stable(cnt));
endmodule

bind rx_test_source rxts_checker #(.W(SAMPLE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rx_enable (rx_enable),
    .rx_reset  (rx_reset),
    .mode      (mode),
    .strobe    (strobe),
    .adc_i     (adc_i),
    .adc_q     (adc_q),
    .tx_i      (tx_i),
    .tx_q      (tx_q),
    .out_i     (out_i),
    .out_q     (out_q),
    .out_valid (out_valid),
    .cnt       (count_q)
);

// File: tb/rx_test_source_tb_top.sv
module rx_test_source_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rx_enable = 1'b0;
    logic         rx_reset = 1'b0;
    logic [2:0]   mode = 3'b000;
    logic         strobe = 1'b0;
    logic [W-1:0] adc_i = '0, adc_q = '0, tx_i = '0, tx_q = '0;
    logic [W-1:0] out_i, out_q;
    logic         out_valid;

    int vectors = 0;
    int errors  = 0;

    logic [2*W-1:0] m_cnt = '0;
    logic [W-1:0]   e_i = '0, e_q = '0;
    logic           e_v = 1'b0;

    always #2.5 clk = ~clk;

    rx_test_source #(.SAMPLE_W(W)) dut_i (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .rx_reset(rx_reset),
        .mode(mode), .strobe(strobe), .adc_i(adc_i), .adc_q(adc_q),
        .tx_i(tx_i), .tx_q(tx_q), .out_i(out_i), .out_q(out_q),
        .out_valid(out_valid)
    );

    task automatic compare(input string req);
        vectors++;
        if (out_valid !== e_v || out_i !== e_i || out_q !== e_q) begin
            errors++;
            $display("FAIL %s: got v=%0b i=%h q=%h, expected v=%0b i=%h q=%h",
                     req, out_valid, out_i, out_q, e_v, e_i, e_q);
        end
    endtask

    // Drive one cycle of stimulus on the falling edge, model the rising edge,
    // and compare on the next falling edge.
    task automatic apply(input logic stb, input logic en, input logic rr,
                         input logic [2:0] md, input logic [W-1:0] ai,
                         input logic [W-1:0] aq, input logic [W-1:0] ti,
                         input logic [W-1:0] tq, input string req);
        strobe = stb; rx_enable = en; rx_reset = rr; mode = md;
        adc_i = ai; adc_q = aq; tx_i = ti; tx_q = tq;
        if (rr) begin
            e_i = '0; e_q = '0; e_v = 1'b0; m_cnt = '0;
        end else if (stb && en) begin
            e_v = 1'b1;
            if (md[2])      begin e_i = m_cnt[W-1:0]; e_q = m_cnt[2*W-1:W]; end
            else if (md[1]) begin e_i = m_cnt[W-1:0]; e_q = ~m_cnt[W-1:0];  end
            else if (md[0]) begin e_i = ti; e_q = tq; end
            else            begin e_i = ai; e_q = aq; end
            m_cnt = m_cnt + 1'b1;
        end else begin
            e_v = 1'b0;
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        e_i = '0; e_q = '0; e_v = 1'b0;
        compare("R1");
        // R1: counter starts at zero (first narrow count sample is 0 / FFFF)
        apply(1, 1, 0, 3'b010, 16'h0, 16'h0, 16'h0, 16'h0, "R1");

        // Sweep all eight mode codes with back-to-back and gapped strobes.
        // R2 R3 R4 R5 R6 R9
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 6; k++) begin
                logic [W-1:0] a = W'(16'h1111 * m + 16'h0101 * k);
                apply(1, 1, 0, 3'(m), a, ~a, a ^ 16'h5A5A, a + 16'h0777,
                      m == 0 ? "R2" : m == 1 ? "R3" : m[2] ? "R5/R6" : "R4/R6");
                if (k[0]) apply(0, 1, 0, 3'(m), ~a, a, a, a, "R9/R10");
            end
        end

        // R7: strobes without enable neither advance the counter nor pulse valid
        for (int k = 0; k < 5; k++)
            apply(1, 0, 0, 3'b010, 16'hDEAD, 16'hBEEF, 16'h1234, 16'h4321, "R7/R9");
        apply(1, 1, 0, 3'b010, 16'h0, 16'h0, 16'h0, 16'h0, "R7");

        // R10: idle cycles hold the last sample
        for (int k = 0; k < 4; k++)
            apply(0, 1, 0, 3'(k), 16'hAAAA, 16'h5555, 16'h0F0F, 16'hF0F0, "R10");

        // R8: receive reset wins over an enabled strobe and clears the counter
        apply(1, 1, 1, 3'b100, 16'h1, 16'h2, 16'h3, 16'h4, "R8");
        apply(1, 1, 1, 3'b010, 16'h1, 16'h2, 16'h3, 16'h4, "R8");
        apply(1, 1, 0, 3'b110, 16'h1, 16'h2, 16'h3, 16'h4, "R8");
        apply(1, 1, 0, 3'b011, 16'h1, 16'h2, 16'h3, 16'h4, "R6");

        // R5 R7: long back-to-back wide run across the low-half carry
        for (int k = 0; k < 66000; k++)
            apply(1, 1, 0, 3'b100, W'(k), W'(k * 3), W'(k * 5), W'(k * 7), "R5/R7");
        apply(1, 1, 0, 3'b101, 16'h0, 16'h0, 16'h0, 16'h0, "R5/R6");
        apply(0, 1, 0, 3'b000, 16'h9, 16'h9, 16'h9, 16'h9, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule